// File: doc/BRIEF.md
# Isochronous IN Frame-Swapped Double Buffer

This block is the transmit storage for one isochronous IN endpoint of a USB device controller. It has two equal banks. The CPU fills one of them a byte at a time. The other is handed to the packet engine, which sends it to the host during the current frame. Each bank keeps its own count of the bytes it holds.

The two banks trade places only when a start-of-frame pulse arrives. Handshakes never cause a swap. On a swap, the bank the CPU filled becomes the packet to send, and its byte count becomes the transmit length. The bank sent in the frame just ended comes back to the CPU empty. A bank the CPU left empty goes out as a zero-length packet.

A per-frame latch records whether the packet engine reported a clean send. At each swap this latch feeds a sticky status flag that the CPU reads and clears. If a start-of-frame pulse arrives while the packet engine is still reading the outgoing bank, the swap waits until that packet completes.

Top module: `iso_in_dbuf`

## Requirements
- R1: After reset, `tx_ok_flag` is 0, `cpu_fill` is 0 and `usb_tx_len` is 0.
- R2: Each cycle with `cpu_wr_en` high stores `cpu_wr_data` at the next free position of the CPU bank, and `cpu_fill` rises by one at the following clock edge.
- R3: A bank holds at most DEPTH (64) bytes. A write to a full CPU bank is ignored, and `cpu_fill` stays at DEPTH.
- R4: Assume the reader is idle, meaning no read has started since the last swap or the last `usb_done`. Then an `sof` pulse swaps the banks at that clock edge. From the next cycle, `usb_tx_len` equals the byte count of the bank the CPU had been filling, `cpu_fill` is 0 and the read position is back at byte 0. A write in the swap cycle itself lands in the outgoing bank and is counted.
- R5: `usb_rd_data` always shows the transmit-bank byte at the current read position. Each cycle with `usb_rd_en` high advances the position by one, so bytes come out in the order the CPU wrote them.
- R6: A bank that received no writes before the swap is sent with `usb_tx_len` equal to 0.
- R7: The banks alternate on every swap. The bank sent in one frame is the bank the CPU writes in the next frame, so the reader always sees data written in the frame just ended.
- R8: `usb_done` with `usb_ok` high marks the current frame as sent cleanly. At the next swap, `tx_ok_flag` becomes 1 at that same edge. A clean `usb_done` in the swap cycle itself also counts.
- R9: `tx_ok_flag` stays 1 across later frames, whatever they report, until the CPU clears it.
- R10: A `stat_clr` pulse clears `tx_ok_flag` at the next edge. If a swap sets the flag in the same cycle, the set wins.
- R11: A frame that ends with no `usb_done`, or only with `usb_done` and `usb_ok` low, leaves `tx_ok_flag` unchanged. The clean-send latch is emptied at each swap, so a clean send never counts for a later frame.
- R12: An `sof` that arrives while a read is in progress is held pending. `cpu_fill`, `usb_tx_len` and the bank roles stay unchanged until the cycle in which `usb_done` arrives, and the swap is applied at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_wr_en | input | 1 | CPU byte write strobe |
| cpu_wr_data | input | 8 | CPU byte to append |
| stat_clr | input | 1 | CPU clear of the transmit-status flag (the write of 0) |
| sof | input | 1 | Start-of-frame pulse, one cycle |
| usb_rd_en | input | 1 | Packet engine consumes the shown byte |
| usb_done | input | 1 | Packet engine finished the current packet |
| usb_ok | input | 1 | Qualifies `usb_done`: the packet went out without error |
| usb_rd_data | output | 8 | Transmit-bank byte at the read position |
| usb_tx_len | output | 7 | Packet length latched at the last swap |
| cpu_fill | output | 7 | Bytes held in the CPU bank |
| tx_ok_flag | output | 1 | Sticky: the previous frame was sent cleanly |

## Verification
The properties assume the packet engine behaves well. `sof`, `usb_done` and `stat_clr` are single-cycle pulses. `usb_rd_en` never coincides with a swap, and it never asks for more bytes than `usb_tx_len`. `usb_ok` only has meaning alongside `usb_done`. The bench drives every input from tasks that raise a strobe for exactly one cycle. It reads only within the latched length and keeps reads out of the cycle that carries `sof`. The one exception is the deferral scenario, where `sof` is deliberately placed inside an unfinished read.

// File: rtl/iso_dbuf_pkg.sv
// Shared types for the isochronous IN double buffer.
// Assumes exactly two banks; a bank is named by one bit.
package iso_dbuf_pkg;
    typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;
endpackage

// File: rtl/iso_dbuf_bank.sv
// One storage bank: appends bytes at its own fill count and serves a random
// read address. Assumes cnt_clr is never raised while this bank is written.
module iso_dbuf_bank #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cnt_clr,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic              room;
    logic [PTR_W-1:0]  wr_addr;

    assign room    = count < CNT_W'(DEPTH);
    assign wr_addr = count[PTR_W-1:0];

    // Store an accepted byte at the append position.
    always_ff @(posedge clk) begin
        if (wr_en && room) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Track the number of stored bytes; cleared when the bank is recycled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (cnt_clr) begin
            count <= '0;
        end else if (wr_en && room) begin
            count <= count + 1'b1;
        end
    end

    // Combinational read of the addressed byte.
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/iso_dbuf_ctrl.sv
// Bank role control: decides when the banks swap (frame start, deferred
// behind an unfinished read) and keeps the transmit read position.
// Assumes single-cycle sof/usb_done pulses.
module iso_dbuf_ctrl
    import iso_dbuf_pkg::*;
#(
    parameter int DEPTH  = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof,
    input  logic             rd_en,
    input  logic             done,
    output logic             swap,
    output bank_e            cpu_sel,
    output logic             busy,
    output logic [CNT_W-1:0] rd_ptr
);
    logic pend_q;
    logic want;

    assign want = sof || pend_q;
    assign swap = want && (!busy || done);

    // Remember a frame start that had to wait for the packet to finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= want && !swap;
        end
    end

    // A read is in progress from its first byte until done or a swap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
        end else if (swap || done) begin
            busy <= 1'b0;
        end else if (rd_en) begin
            busy <= 1'b1;
        end
    end

    // Flip the CPU bank on each swap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_sel <= BANK_A;
        end else if (swap) begin
            cpu_sel <= (cpu_sel == BANK_A) ? BANK_B : BANK_A;
        end
    end

    // Read position: restarts on swap, saturates at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (swap) begin
            rd_ptr <= '0;
        end else if (rd_en && rd_ptr < CNT_W'(DEPTH)) begin
            rd_ptr <= rd_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/iso_dbuf_status.sv
// Per-frame clean-send latch and the sticky CPU-visible status flag.
// Assumes usb_ok is only meaningful together with done.
module iso_dbuf_status (
    input  logic clk,
    input  logic rst_n,
    input  logic swap,
    input  logic done,
    input  logic ok,
    input  logic clr,
    output logic flag
);
    logic sent_ok_q;
    logic clean_now;

    assign clean_now = done && ok;

    // Clean-send latch for the frame in progress; emptied at each swap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent_ok_q <= 1'b0;
        end else if (swap) begin
            sent_ok_q <= 1'b0;
        end else if (clean_now) begin
            sent_ok_q <= 1'b1;
        end
    end

    // Sticky flag: set at swap from the latch, set beats CPU clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (swap && (sent_ok_q || clean_now)) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/iso_in_dbuf.sv
// Top of the isochronous IN double buffer: two banks, frame-driven swap,
// transmit length latch and status flag. Assumes the packet engine reads no
// further than usb_tx_len and does not read in a swap cycle.
module iso_in_dbuf
    import iso_dbuf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr_en,
    input  logic [DATA_W-1:0] cpu_wr_data,
    input  logic              stat_clr,
    input  logic              sof,
    input  logic              usb_rd_en,
    input  logic              usb_done,
    input  logic              usb_ok,
    output logic [DATA_W-1:0] usb_rd_data,
    output logic [CNT_W-1:0]  usb_tx_len,
    output logic [CNT_W-1:0]  cpu_fill,
    output logic              tx_ok_flag
);
    logic              swap;
    bank_e             cpu_sel;
    logic              busy;
    logic [CNT_W-1:0]  rd_ptr;
    logic [DATA_W-1:0] bank_rd  [2];
    logic [CNT_W-1:0]  bank_cnt [2];
    logic              cpu_room;

    iso_dbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .sof     (sof),
        .rd_en   (usb_rd_en),
        .done    (usb_done),
        .swap    (swap),
        .cpu_sel (cpu_sel),
        .busy    (busy),
        .rd_ptr  (rd_ptr)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic is_cpu;
        assign is_cpu = (cpu_sel == bank_e'(b));
        iso_dbuf_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cpu_wr_en && is_cpu),
            .wr_data (cpu_wr_data),
            .cnt_clr (swap && !is_cpu),
            .rd_addr (rd_ptr[PTR_W-1:0]),
            .rd_data (bank_rd[b]),
            .count   (bank_cnt[b])
        );
    end

    iso_dbuf_status u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .swap  (swap),
        .done  (usb_done),
        .ok    (usb_ok),
        .clr   (stat_clr),
        .flag  (tx_ok_flag)
    );

    assign cpu_fill    = bank_cnt[cpu_sel];
    assign usb_rd_data = bank_rd[~cpu_sel];
    assign cpu_room    = cpu_fill < CNT_W'(DEPTH);

    // Latch the outgoing bank length, including a write in the swap cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            usb_tx_len <= '0;
        end else if (swap) begin
            usb_tx_len <= cpu_fill + CNT_W'(cpu_wr_en && cpu_room);
        end
    end
endmodule

// File: rtl/iso_in_dbuf_chk.sv
// Property checker for iso_in_dbuf, attached by bind.
module iso_in_dbuf_chk #(
    parameter int DEPTH  = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sof,
    input logic             usb_done,
    input logic             usb_ok,
    input logic             cpu_wr_en,
    input logic             stat_clr,
    input logic [CNT_W-1:0] cpu_fill,
    input logic [CNT_W-1:0] usb_tx_len,
    input logic             tx_ok_flag,
    input logic             swap,
    input logic             cpu_sel,
    input logic             busy,
    input logic [CNT_W-1:0] rd_ptr
);
    assert_len_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        usb_tx_len <= CNT_W'(DEPTH));
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_fill == CNT_W'(DEPTH) && cpu_wr_en && !swap |=> cpu_fill == CNT_W'(DEPTH));
    assert_swap_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> cpu_fill == '0 && rd_ptr == '0);
    assert_swap_alternate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> cpu_sel != $past(cpu_sel));
    assert_ok_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        swap && usb_done && usb_ok |=> tx_ok_flag);
    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ok_flag && !stat_clr |=> tx_ok_flag);
    assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr && !swap |=> !tx_ok_flag);
    assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_ok_flag && !swap |=> !tx_ok_flag);
    assert_defer_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sof && busy && !usb_done |=> $stable(cpu_sel) && $stable(usb_tx_len));
endmodule

bind iso_in_dbuf iso_in_dbuf_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sof        (sof),
    .usb_done   (usb_done),
    .usb_ok     (usb_ok),
    .cpu_wr_en  (cpu_wr_en),
    .stat_clr   (stat_clr),
    .cpu_fill   (cpu_fill),
    .usb_tx_len (usb_tx_len),
    .tx_ok_flag (tx_ok_flag),
    .swap       (swap),
    .cpu_sel    (cpu_sel),
    .busy       (busy),
    .rd_ptr     (rd_ptr)
);

// File: tb/iso_in_dbuf_tb.sv
module iso_in_dbuf_tb;
    localparam int DEPTH = 64;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_wr_en = 1'b0;
    logic [7:0]    cpu_wr_data = '0;
    logic          stat_clr = 1'b0;
    logic          sof = 1'b0;
    logic          usb_rd_en = 1'b0;
    logic          usb_done = 1'b0;
    logic          usb_ok = 1'b0;
    logic [7:0]    usb_rd_data;
    logic [CW-1:0] usb_tx_len;
    logic [CW-1:0] cpu_fill;
    logic          tx_ok_flag;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    iso_in_dbuf #(.DATA_W(8), .DEPTH(DEPTH)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_wr_en   (cpu_wr_en),
        .cpu_wr_data (cpu_wr_data),
        .stat_clr    (stat_clr),
        .sof         (sof),
        .usb_rd_en   (usb_rd_en),
        .usb_done    (usb_done),
        .usb_ok      (usb_ok),
        .usb_rd_data (usb_rd_data),
        .usb_tx_len  (usb_tx_len),
        .cpu_fill    (cpu_fill),
        .tx_ok_flag  (tx_ok_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Advance one clock; inputs change and outputs are sampled 1 ns after the edge.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_byte(input logic [7:0] d);
        cpu_wr_en = 1'b1; cpu_wr_data = d;
        step();
        cpu_wr_en = 1'b0;
    endtask

    task automatic pulse_sof();
        sof = 1'b1; step(); sof = 1'b0;
    endtask

    task automatic finish_pkt(input logic ok);
        usb_done = 1'b1; usb_ok = ok; step();
        usb_done = 1'b0; usb_ok = 1'b0;
    endtask

    task automatic clear_flag();
        stat_clr = 1'b1; step(); stat_clr = 1'b0;
    endtask

    // Check the shown byte, then consume it.
    task automatic rd_check(input string req, input logic [7:0] exp);
        check(req, usb_rd_data, exp);
        usb_rd_en = 1'b1; step(); usb_rd_en = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 flag", tx_ok_flag, 0);
        check("R1 fill", cpu_fill, 0);
        check("R1 len", usb_tx_len, 0);
    endtask

    task automatic t_fill_swap();
        for (int i = 0; i < 5; i++) wr_byte(8'h10 + 8'(i));
        check("R2 fill", cpu_fill, 5);
        pulse_sof();
        check("R4 len", usb_tx_len, 5);
        check("R4 fill", cpu_fill, 0);
        for (int i = 0; i < 5; i++) rd_check("R5 data", 8'h10 + 8'(i));
        finish_pkt(1'b1);
        check("R11 flag before swap", tx_ok_flag, 0);
    endtask

    task automatic t_ok_flag();
        pulse_sof();
        check("R8 flag", tx_ok_flag, 1);
        check("R6 empty len", usb_tx_len, 0);
    endtask

    task automatic t_sticky();
        pulse_sof();
        check("R9 sticky", tx_ok_flag, 1);
        finish_pkt(1'b0);
        pulse_sof();
        check("R9 sticky after bad", tx_ok_flag, 1);
        clear_flag();
        check("R10 clear", tx_ok_flag, 0);
    endtask

    task automatic t_no_leak();
        finish_pkt(1'b0);
        pulse_sof();
        check("R11 bad frame", tx_ok_flag, 0);
        finish_pkt(1'b1);
        pulse_sof();
        check("R8 flag again", tx_ok_flag, 1);
        clear_flag();
        pulse_sof();
        check("R11 no leak", tx_ok_flag, 0);
    endtask

    task automatic t_set_wins();
        finish_pkt(1'b1);
        sof = 1'b1; stat_clr = 1'b1; step(); sof = 1'b0; stat_clr = 1'b0;
        check("R10 set wins", tx_ok_flag, 1);
        clear_flag();
        check("R10 clear2", tx_ok_flag, 0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 70; i++) wr_byte(8'(i));
        check("R3 fill cap", cpu_fill, DEPTH);
        pulse_sof();
        check("R3 len cap", usb_tx_len, DEPTH);
        for (int i = 0; i < DEPTH; i++) begin
            if (i == 0 || i == DEPTH - 1) rd_check("R3 data", 8'(i));
            else begin usb_rd_en = 1'b1; step(); usb_rd_en = 1'b0; end
        end
        finish_pkt(1'b0);
    endtask

    task automatic t_alternate();
        for (int i = 0; i < 4; i++) wr_byte(8'hA0 + 8'(i));
        pulse_sof();
        for (int i = 0; i < 4; i++) wr_byte(8'hB0 + 8'(i));
        check("R7 tx holds A", usb_rd_data, 8'hA0);
        pulse_sof();
        check("R7 len", usb_tx_len, 4);
        check("R7 fill", cpu_fill, 0);
        for (int i = 0; i < 4; i++) rd_check("R7 data B", 8'hB0 + 8'(i));
        finish_pkt(1'b0);
    endtask

    task automatic t_defer();
        for (int i = 0; i < 3; i++) wr_byte(8'h30 + 8'(i));
        pulse_sof();
        rd_check("R5 first", 8'h30);
        wr_byte(8'h40); wr_byte(8'h41);
        pulse_sof();
        check("R12 fill held", cpu_fill, 2);
        check("R12 len held", usb_tx_len, 3);
        rd_check("R12 data", 8'h31);
        rd_check("R12 data", 8'h32);
        check("R12 still held", cpu_fill, 2);
        finish_pkt(1'b1);
        check("R12 len after done", usb_tx_len, 2);
        check("R12 fill after done", cpu_fill, 0);
        check("R8 flag on deferred swap", tx_ok_flag, 1);
        check("R12 new data", usb_rd_data, 8'h40);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_fill_swap();
        t_ok_flag();
        t_sticky();
        t_no_leak();
        t_set_wins();
        t_overflow();
        t_alternate();
        t_defer();
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule